// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page-table entries so that most virtual-to-physical translations finish without a trip to memory. A virtual address enters on a lookup channel. The block compares it against the four ways of one of sixteen sets. One cycle later it returns the answer on a response channel. A hit carries the physical address and the low flag bits of the cached entry. A miss is a request to the page walker. The walker later installs what it fetched through a fill channel.

Each way holds a valid bit, a kind flag, a 16-bit tag and a 32-bit cached page entry. The kind flag marks the entry as directory level or table level. A table-level match is a translation hit. A directory-level match is not a hit. It is reported as a miss that carries the cached directory entry, so that the walker can skip the first level of its walk.

Two flush inputs invalidate entries. The task flush keeps entries that are marked global. The full flush clears everything.

Lookup and response use valid/ready handshakes. The response register is a single stage:
- `lk_ready` is high only when the response slot is empty or is being drained in the same cycle.
- A response that is not accepted holds every field stable.
- Fills and flushes take priority over lookups. While either is present, `lk_ready` is low.
- A flush takes priority over a fill. While a flush is present, `fill_ready` is low.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid` is low, `lk_ready` is high, and the first lookup returns a miss.
- R2: A lookup whose set (virtual address bits 15:12) holds a valid table-level entry (kind flag 0) with a tag equal to address bits 31:16 responds one cycle after acceptance with the following values:
  - `rsp_hit`=1 and `rsp_walk`=0.
  - `rsp_paddr` = {entry bits 31:12, address bits 11:0}.
  - `rsp_flags` = entry bits 11:0.
  - `rsp_entry` = the entry.
- R3: A lookup with no valid entry of matching tag in its set responds with `rsp_hit`=0, `rsp_walk`=1, `rsp_dir`=0, and `rsp_paddr`, `rsp_flags` and `rsp_entry` all zero.
- R4: A lookup that matches only a directory-level entry (kind flag 1) responds with `rsp_hit`=0, `rsp_walk`=1, `rsp_dir`=1 and `rsp_entry` = that directory entry. `rsp_paddr` and `rsp_flags` are zero.
- R5: Up to four entries with distinct tags can live in one set at the same time, and all of them hit.
- R6: A fill that finds no entry of the same tag and kind goes to the lowest-numbered invalid way. When no way is invalid, it replaces the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one on each such replacement.
- R7: A fill whose tag and kind match a valid entry of its set overwrites that entry in place. No other entry is disturbed, and no two ways of a set ever match the same tag and kind.
- R8: A task flush invalidates every entry whose cached entry has bit 8 (global) clear. Entries with bit 8 set still hit afterwards.
- R9: A full flush invalidates every entry, global ones included.
- R10: While `rsp_valid` is high and `rsp_ready` is low, all response fields stay stable and `lk_ready` is low.
- R11: `lk_ready` is low while `fill_valid`, `flush_task` or `flush_all` is high. `fill_ready` is low while either flush is high.
- R12: Sets are independent. The same tag in different sets holds different entries, and a fill changes only the set selected by the fill page number bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_hit | output | 1 | Table-level translation hit |
| rsp_dir | output | 1 | Miss that matched a cached directory entry |
| rsp_walk | output | 1 | Page walk needed (not a hit) |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| rsp_flags | output | 12 | Low flag bits of the hit entry, else zero |
| rsp_entry | output | 32 | Matched cached entry (table or directory), else zero |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_is_dir | input | 1 | Kind flag of the installed entry (1 = directory level) |
| fill_entry | input | 32 | Page entry to install |
| flush_task | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The main function is first driven with directed sequences:
- Five and six distinct tags into one set. This separates the invalid-first choice from round-robin replacement and shows the pointer advancing.
- A directory entry and a table entry sharing a tag. This shows that the kind flag decides between hit and directory report.
- A refill of an existing tag. This tells an in-place update apart from an eviction.
- Mixed global and non-global entries across a task flush and then a full flush.

Constrained random traffic then draws a small pool of tags over four sets, so that sets fill, evict and collide often. Fill, lookup and both flushes are interleaved, and every response is compared with a reference model of the requirements. A stalled response channel and fills placed next to lookups check the handshake rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned ENT_W     = 32;
  localparam int unsigned GLOBAL_BT = 8;

  typedef struct packed {
    logic             hit;
    logic             dir;
    logic [VA_W-1:0]  paddr;
    logic [OFF_W-1:0] flags;
    logic [ENT_W-1:0] entry;
  } tlb_result_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned ENT_W  = 32,
  parameter int unsigned GBIT   = 8,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_task,
  input  logic                        flush_all,
  input  logic                        we,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_dir,
  input  logic [ENT_W-1:0]            wr_ent,
  input  logic [SET_W-1:0]            ra_set,
  output logic [WAYS-1:0]             ra_valid,
  output logic [WAYS-1:0][TAG_W-1:0]  ra_tag,
  output logic [WAYS-1:0]             ra_dir,
  output logic [WAYS-1:0][ENT_W-1:0]  ra_ent,
  input  logic [SET_W-1:0]            rb_set,
  output logic [WAYS-1:0]             rb_valid,
  output logic [WAYS-1:0][TAG_W-1:0]  rb_tag,
  output logic [WAYS-1:0]             rb_dir
);
  logic             valid_q [SETS][WAYS];
  logic             dir_q   [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [ENT_W-1:0] ent_q   [SETS][WAYS];

  // Valid bits: reset, flush and write.
  always_ff @(posedge clk) begin
    if (!rst_n || flush_all) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          valid_q[s][w] <= 1'b0;
    end else begin
      if (flush_task) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (!ent_q[s][w][GBIT]) valid_q[s][w] <= 1'b0;
      end
      if (we) valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  // Payload needs no reset: valid gates every use.
  always_ff @(posedge clk) begin
    if (we) begin
      dir_q[wr_set][wr_way] <= wr_dir;
      tag_q[wr_set][wr_way] <= wr_tag;
      ent_q[wr_set][wr_way] <= wr_ent;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      ra_valid[w] = valid_q[ra_set][w];
      ra_tag[w]   = tag_q[ra_set][w];
      ra_dir[w]   = dir_q[ra_set][w];
      ra_ent[w]   = ent_q[ra_set][w];
      rb_valid[w] = valid_q[rb_set][w];
      rb_tag[w]   = tag_q[rb_set][w];
      rb_dir[w]   = dir_q[rb_set][w];
    end
  end

  logic any_live, nonglobal_live;
  always_comb begin
    any_live       = 1'b0;
    nonglobal_live = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        any_live       = any_live | valid_q[s][w];
        nonglobal_live = nonglobal_live | (valid_q[s][w] & ~ent_q[s][w][GBIT]);
      end
  end

  assert_task_flush_keeps_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_task |=> !nonglobal_live);
  assert_full_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !any_live);
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_dir,
  input  logic [TAG_W-1:0]           q_tag,
  output logic [WAYS-1:0]            tbl_m,
  output logic [WAYS-1:0]            dir_m
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic eq;
    assign eq       = way_valid[w] && (way_tag[w] == q_tag);
    assign tbl_m[w] = eq && !way_dir[w];
    assign dir_m[w] = eq &&  way_dir[w];
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAYS-1:0]  same_m,
  input  logic             commit,
  output logic [WAY_W-1:0] way,
  output logic             replace
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic             found;

  always_comb begin
    way     = ptr_q[set_idx];
    replace = 1'b0;
    found   = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!found && same_m[w]) begin
        way   = WAY_W'(w);
        found = 1'b1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && !way_valid[w]) begin
        way   = WAY_W'(w);
        found = 1'b1;
      end
    if (!found) replace = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (commit && replace) begin
      if (ptr_q[set_idx] == WAY_W'(WAYS - 1)) ptr_q[set_idx] <= '0;
      else                                    ptr_q[set_idx] <= ptr_q[set_idx] + 1'b1;
    end
  end

  assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $onehot0(same_m));
  assert_replace_only_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && replace) |-> (&way_valid));
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int unsigned SETS   = 16,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned TAG_W = VPN_W - SET_W,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [31:0]      lk_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_dir,
  output logic             rsp_walk,
  output logic [31:0]      rsp_paddr,
  output logic [11:0]      rsp_flags,
  output logic [31:0]      rsp_entry,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [19:0]      fill_vpn,
  input  logic             fill_is_dir,
  input  logic [31:0]      fill_entry,
  input  logic             flush_task,
  input  logic             flush_all
);
  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = lk_vaddr[OFF_W +: SET_W];
  assign lk_tag = lk_vaddr[OFF_W + SET_W +: TAG_W];
  assign fl_set = fill_vpn[SET_W-1:0];
  assign fl_tag = fill_vpn[SET_W +: TAG_W];

  logic any_flush, fill_go, lk_go;
  assign any_flush  = flush_task | flush_all;
  assign fill_ready = !any_flush;
  assign fill_go    = fill_valid && fill_ready;
  assign lk_ready   = (!rsp_valid || rsp_ready) && !fill_valid && !any_flush;
  assign lk_go      = lk_valid && lk_ready;

  logic [WAYS-1:0]            a_valid, a_dir, b_valid, b_dir;
  logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
  logic [WAYS-1:0][ENT_W-1:0] a_ent;
  logic [WAY_W-1:0]           vic_way;
  logic                       vic_replace;

  tlb_entry_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ENT_W(ENT_W), .GBIT(GLOBAL_BT))
  i_store (
    .clk(clk), .rst_n(rst_n), .flush_task(flush_task), .flush_all(flush_all),
    .we(fill_go), .wr_set(fl_set), .wr_way(vic_way), .wr_tag(fl_tag),
    .wr_dir(fill_is_dir), .wr_ent(fill_entry),
    .ra_set(lk_set), .ra_valid(a_valid), .ra_tag(a_tag), .ra_dir(a_dir), .ra_ent(a_ent),
    .rb_set(fl_set), .rb_valid(b_valid), .rb_tag(b_tag), .rb_dir(b_dir)
  );

  logic [WAYS-1:0] lk_tbl_m, lk_dir_m, fl_tbl_m, fl_dir_m, fl_same_m;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match_lk (
    .way_valid(a_valid), .way_tag(a_tag), .way_dir(a_dir), .q_tag(lk_tag),
    .tbl_m(lk_tbl_m), .dir_m(lk_dir_m)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match_fl (
    .way_valid(b_valid), .way_tag(b_tag), .way_dir(b_dir), .q_tag(fl_tag),
    .tbl_m(fl_tbl_m), .dir_m(fl_dir_m)
  );

  assign fl_same_m = fill_is_dir ? fl_dir_m : fl_tbl_m;

  tlb_victim #(.SETS(SETS), .WAYS(WAYS)) i_victim (
    .clk(clk), .rst_n(rst_n), .set_idx(fl_set), .way_valid(b_valid),
    .same_m(fl_same_m), .commit(fill_go), .way(vic_way), .replace(vic_replace)
  );

  // Select the matched entry; table match wins over directory match.
  tlb_result_t res;
  logic [ENT_W-1:0] tbl_ent, dir_ent;
  always_comb begin
    tbl_ent = '0;
    dir_ent = '0;
    for (int w = 0; w < WAYS; w++) begin
      tbl_ent = tbl_ent | (a_ent[w] & {ENT_W{lk_tbl_m[w]}});
      dir_ent = dir_ent | (a_ent[w] & {ENT_W{lk_dir_m[w]}});
    end
    res = '0;
    if (|lk_tbl_m) begin
      res.hit   = 1'b1;
      res.paddr = {tbl_ent[ENT_W-1:OFF_W], lk_vaddr[OFF_W-1:0]};
      res.flags = tbl_ent[OFF_W-1:0];
      res.entry = tbl_ent;
    end else if (|lk_dir_m) begin
      res.dir   = 1'b1;
      res.entry = dir_ent;
    end
  end

  tlb_result_t rsp_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          rsp_valid <= 1'b0;
    else if (lk_go)      rsp_valid <= 1'b1;
    else if (rsp_ready)  rsp_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rsp_q <= '0;
    else if (lk_go) rsp_q <= res;
  end

  assign rsp_hit   = rsp_q.hit;
  assign rsp_dir   = rsp_q.dir;
  assign rsp_walk  = !rsp_q.hit;
  assign rsp_paddr = rsp_q.paddr;
  assign rsp_flags = rsp_q.flags;
  assign rsp_entry = rsp_q.entry;

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)
                                   && $stable(rsp_entry) && $stable(rsp_dir)));
  assert_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || any_flush) |-> !lk_ready);
  assert_dir_not_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_dir));
endmodule

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, rsp_ready = 1'b1, fill_valid = 1'b0, fill_is_dir = 1'b0;
  logic flush_task = 1'b0, flush_all = 1'b0;
  logic [31:0] lk_vaddr = '0, fill_entry = '0;
  logic [19:0] fill_vpn = '0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_dir, rsp_walk, fill_ready;
  logic [31:0] rsp_paddr, rsp_entry;
  logic [11:0] rsp_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_cache i_tlb_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_dir(rsp_dir),
    .rsp_walk(rsp_walk), .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags), .rsp_entry(rsp_entry),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_is_dir(fill_is_dir), .fill_entry(fill_entry),
    .flush_task(flush_task), .flush_all(flush_all)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference model, built from the requirements.
  bit          m_valid [NS][NW];
  bit          m_dir   [NS][NW];
  bit [15:0]   m_tag   [NS][NW];
  bit [31:0]   m_ent   [NS][NW];
  int          m_ptr   [NS];

  task automatic check(input string req, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit [65:0] model_look(input bit [31:0] va);
    // {hit, dir, paddr, entry}
    int s = va[15:12];
    bit [15:0] t = va[31:16];
    for (int w = 0; w < NW; w++)
      if (m_valid[s][w] && m_tag[s][w] == t && !m_dir[s][w])
        return {1'b1, 1'b0, m_ent[s][w][31:12], va[11:0], m_ent[s][w]};
    for (int w = 0; w < NW; w++)
      if (m_valid[s][w] && m_tag[s][w] == t && m_dir[s][w])
        return {1'b0, 1'b1, 32'h0, m_ent[s][w]};
    return '0;
  endfunction

  task automatic model_fill(input bit [19:0] vpn, input bit d, input bit [31:0] e);
    int s = vpn[3:0];
    int way = -1;
    for (int w = 0; w < NW; w++)
      if (way < 0 && m_valid[s][w] && m_tag[s][w] == vpn[19:4] && m_dir[s][w] == d) way = w;
    for (int w = 0; w < NW; w++)
      if (way < 0 && !m_valid[s][w]) way = w;
    if (way < 0) begin
      way = m_ptr[s];
      m_ptr[s] = (m_ptr[s] + 1) % NW;
    end
    m_valid[s][way] = 1'b1;
    m_dir[s][way] = d;
    m_tag[s][way] = vpn[19:4];
    m_ent[s][way] = e;
  endtask

  task automatic do_lookup(input string req, input bit [31:0] va);
    bit [65:0] ex;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    ex = model_look(va);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, rsp_valid === 1'b1, "rsp_valid", {63'b0, rsp_valid}, 64'd1);
    check(req, rsp_hit === ex[65] && rsp_dir === ex[64] && rsp_walk === !ex[65],
          "hit/dir/walk", {61'b0, rsp_hit, rsp_dir, rsp_walk}, {61'b0, ex[65], ex[64], !ex[65]});
    check(req, rsp_paddr === ex[63:32] && rsp_entry === ex[31:0] &&
          rsp_flags === (ex[65] ? ex[11:0] : 12'h0),
          "paddr/entry", {rsp_paddr, rsp_entry}, ex[63:0]);
  endtask

  task automatic do_fill(input bit [19:0] vpn, input bit d, input bit [31:0] e);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn = vpn;
    fill_is_dir = d;
    fill_entry = e;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    model_fill(vpn, d, e);
  endtask

  task automatic do_flush(input bit full);
    @(negedge clk);
    if (full) flush_all = 1'b1; else flush_task = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush_all = 1'b0;
    flush_task = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (full || !m_ent[s][w][8]) m_valid[s][w] = 1'b0;
  endtask

  function automatic bit [31:0] va_of(input bit [15:0] tag, input bit [3:0] set, input bit [11:0] off);
    return {tag, set, off};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20071031));
    for (int s = 0; s < NS; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < NW; w++) m_valid[s][w] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state and empty array
    check("R1", rsp_valid === 1'b0, "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
    check("R1", lk_ready === 1'b1, "lk_ready after reset", {63'b0, lk_ready}, 64'd1);
    do_lookup("R1", va_of(16'h0000, 4'h0, 12'h000));
    do_lookup("R3", va_of(16'hBEEF, 4'h5, 12'h123));

    // R2: basic table hit
    do_fill({16'hBEEF, 4'h5}, 1'b0, 32'h12345_1A7);
    do_lookup("R2", va_of(16'hBEEF, 4'h5, 12'hABC));

    // R5, R6: fill set 5 up and then beyond
    do_fill({16'h0001, 4'h5}, 1'b0, 32'hA0001_003);
    do_fill({16'h0002, 4'h5}, 1'b0, 32'hA0002_005);
    do_fill({16'h0003, 4'h5}, 1'b0, 32'hA0003_007);
    do_lookup("R5", va_of(16'hBEEF, 4'h5, 12'h010));
    do_lookup("R5", va_of(16'h0003, 4'h5, 12'h020));
    do_fill({16'h0004, 4'h5}, 1'b0, 32'hA0004_009);
    do_lookup("R6", va_of(16'hBEEF, 4'h5, 12'h010));
    do_lookup("R6", va_of(16'h0004, 4'h5, 12'h030));
    do_fill({16'h0006, 4'h5}, 1'b0, 32'hA0006_00B);
    do_lookup("R6", va_of(16'h0001, 4'h5, 12'h040));
    do_lookup("R6", va_of(16'h0002, 4'h5, 12'h050));

    // R4: directory-level entry reported, not a hit
    do_fill({16'h7777, 4'h9}, 1'b1, 32'h55555_021);
    do_lookup("R4", va_of(16'h7777, 4'h9, 12'h888));
    do_fill({16'h7777, 4'h9}, 1'b0, 32'h66666_001);
    do_lookup("R4", va_of(16'h7777, 4'h9, 12'h888));

    // R7: refill in place keeps the other entries
    do_fill({16'h0004, 4'h5}, 1'b0, 32'hCCCC4_0F1);
    do_lookup("R7", va_of(16'h0004, 4'h5, 12'h001));
    do_lookup("R7", va_of(16'h0006, 4'h5, 12'h001));
    do_lookup("R7", va_of(16'h0002, 4'h5, 12'h001));

    // R12: same tag, different sets
    do_fill({16'h4242, 4'h1}, 1'b0, 32'h11111_001);
    do_fill({16'h4242, 4'h2}, 1'b0, 32'h22222_001);
    do_lookup("R12", va_of(16'h4242, 4'h1, 12'h00F));
    do_lookup("R12", va_of(16'h4242, 4'h2, 12'h00F));
    do_lookup("R12", va_of(16'h4242, 4'h3, 12'h00F));

    // R8: task flush keeps global entries (bit 8)
    do_fill({16'h9000, 4'hA}, 1'b0, 32'h90000_101);
    do_fill({16'h9001, 4'hA}, 1'b0, 32'h90001_001);
    do_flush(1'b0);
    do_lookup("R8", va_of(16'h9000, 4'hA, 12'h004));
    do_lookup("R8", va_of(16'h9001, 4'hA, 12'h004));
    do_lookup("R8", va_of(16'h4242, 4'h1, 12'h004));
    // R9: full flush clears global ones too
    do_flush(1'b1);
    do_lookup("R9", va_of(16'h9000, 4'hA, 12'h004));

    // R10: stalled response holds
    do_fill({16'h3333, 4'h3}, 1'b0, 32'h33333_0FF);
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1;
    lk_vaddr = va_of(16'h3333, 4'h3, 12'h777);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    lk_vaddr = va_of(16'h0BAD, 4'h3, 12'h000);
    @(posedge clk);
    @(negedge clk);
    check("R10", rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_paddr === 32'h33333_777,
          "held response", {rsp_valid, rsp_hit, rsp_paddr}, {2'b11, 32'h33333_777});
    check("R10", lk_ready === 1'b0, "lk_ready stalled", {63'b0, lk_ready}, 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10", rsp_valid === 1'b0, "drained", {63'b0, rsp_valid}, 64'd0);

    // R11: priorities
    fill_valid = 1'b1;
    fill_vpn = 20'h12340;
    fill_entry = 32'hF0F0F_001;
    fill_is_dir = 1'b0;
    #1;
    check("R11", lk_ready === 1'b0, "lk_ready during fill", {63'b0, lk_ready}, 64'd0);
    flush_all = 1'b1;
    #1;
    check("R11", fill_ready === 1'b0, "fill_ready during flush", {63'b0, fill_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    flush_all = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) m_valid[s][w] = 1'b0;
    do_lookup("R11", va_of(16'h1234, 4'h0, 12'h000));

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(99);
      bit [15:0] t = 16'($urandom_range(5));
      bit [3:0]  s = 4'($urandom_range(3));
      if (op < 45) begin
        bit [31:0] e = $urandom;
        e[8] = ($urandom_range(3) == 0);
        do_fill({t, s}, ($urandom_range(3) == 0), e);
      end else if (op < 97) begin
        do_lookup("R2", va_of(t, s, 12'($urandom)));
      end else if (op < 99) begin
        do_flush(1'b0);
      end else begin
        do_flush(1'b1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule